// File: doc/BRIEF.md
# Oldest-Ready Issue Selector with Age Matrix

This block is the selection core of an instruction scheduler. It holds `N` slots and a square array of relative-age bits between them. Each bit says whether one slot was filled before another. The environment fills a slot by giving its index on the allocate strobe and frees a slot on the deallocate strobe. Finding a free slot, waking up operands, storing payloads and deciding when a granted slot is freed all stay outside the block.

Every cycle the block takes a ready bit per slot and a port-request bit per slot and port. For each of `P` issue ports it returns a one-hot grant and a valid flag. The grant names the slot that was filled earliest among the slots that are occupied, ready and requesting that port. All port pickers read the same age array in parallel. The path from ready and request to grant is purely combinational: a masked AND-reduction per slot, with no chain of counter comparisons.

Age means the order in which slots were filled. A slot that is filled again after being freed becomes the youngest entry. Holes left by freed slots never win. The block does not renumber or compact anything.

Top module: `age_oldest_select`

## Requirements
- R1: While `rstN` is low and in the first cycle after reset, no slot is occupied, every bit of `grantVec` is 0 and every bit of `grantValid` is 0, whatever `readyVec` and `reqPort` hold.
- R2: A grant goes only to a slot that is occupied, has its `readyVec` bit set and requests that port. An empty or freed slot is never granted, even if its stale ready and request bits are set.
- R3: For each port, the grant goes to the eligible slot that was allocated earliest. Allocation order is the order of the clock edges at which `allocEn` was sampled high for each slot.
- R4: A slot allocated at an edge is younger than every slot that is occupied after that edge. This holds even when the same index was used before.
- R5: Deallocating a slot removes it from all ordering. The relative order of the remaining slots is unchanged.
- R6: When `allocEn` and `deallocEn` name the same slot at the same edge, the slot stays occupied and becomes the youngest entry.
- R7: Each port is picked independently, in the same cycle, from the same age state. Request bit `reqPort[s*P+p]` means slot `s` requests port `p`. Grant bit `grantVec[p*N+s]` means slot `s` is granted on port `p`.
- R8: When no slot is eligible for port `p`, `grantVec[p*N +: N]` is all zeros and `grantValid[p]` is 0. Otherwise `grantValid[p]` is 1.
- R9: A change on `readyVec` or `reqPort` is reflected in the grants within the same cycle, with no register on the path.
- R10: Each port's grant slice has at most one bit set.
- R11: A slot allocated at an edge is a candidate from the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocEn | input | 1 | Fill the slot given by allocIdx at this edge |
| allocIdx | input | IW = $clog2(N) | Slot index to fill |
| deallocEn | input | 1 | Free the slot given by deallocIdx at this edge |
| deallocIdx | input | IW | Slot index to free |
| readyVec | input | N | Per-slot ready bit |
| reqPort | input | N*P | Port request, bit s*P+p for slot s and port p |
| grantVec | output | N*P | One-hot grant per port, bit p*N+s |
| grantValid | output | P | Port p has a grant |

## Verification
A table of ready masks and port splits runs against six slots that were filled in scrambled index order. Some patterns give the oldest slot a low index and some a high one, so a picker that uses slot index instead of age gives a different answer. The patterns also split the slots between the two ports in different ways, which separates independent per-port picking from a shared winner. Ready bits are driven on empty slots, on a slot that was just freed and on a slot that was refilled, which separates gating by occupancy and allocation-order aging from stale state. Changing ready in the middle of a cycle shows whether a register sits on the grant path.

// File: rtl/age_sel_pkg.sv
package age_sel_pkg;

  // Strobes passed from the control part to the age-array datapath
  typedef struct packed {
    logic allocHit;
    logic deallocHit;
  } ageStrobeT;

endpackage

// File: rtl/age_sel_ctrl.sv
module age_sel_ctrl
  import age_sel_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          allocEn,
  input  logic [IW-1:0] allocIdx,
  input  logic          deallocEn,
  input  logic [IW-1:0] deallocIdx,
  output ageStrobeT     strobe,
  output logic [N-1:0]  allocMask,
  output logic [N-1:0]  deallocMask,
  output logic [N-1:0]  validVec,
  output logic [N-1:0]  survivorVec
);

  logic [N-1:0] validNext;

  always_comb begin
    allocMask   = allocEn   ? (N'(1) << allocIdx)   : '0;
    deallocMask = deallocEn ? (N'(1) << deallocIdx) : '0;
    strobe.allocHit   = allocEn;
    strobe.deallocHit = deallocEn;
    // Slots still present after this edge, apart from the one being filled
    survivorVec = validVec & ~deallocMask & ~allocMask;
    // Freeing is applied first, so filling the same slot keeps it occupied
    validNext   = (validVec & ~deallocMask) | allocMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validVec <= '0;
    else       validVec <= validNext;
  end

  // R11: an allocated slot is occupied in the following cycle
  assert_alloc_sets_R11: assert property (@(posedge clk) disable iff (!rstN)
    allocEn |=> validVec[$past(allocIdx)]);

  // R5: a freed slot (not refilled at the same edge) is empty afterwards
  assert_dealloc_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (deallocEn && !(allocEn && allocIdx == deallocIdx)) |=> !validVec[$past(deallocIdx)]);

endmodule

// File: rtl/age_sel_picker.sv
module age_sel_picker #(
  parameter int N = 16
) (
  input  logic [N-1:0]   cand,
  input  logic [N*N-1:0] olderCols,
  output logic [N-1:0]   grant,
  output logic           anyGrant
);

  // olderCols[s*N+j] set: slot j is older than slot s
  always_comb begin
    for (int s = 0; s < N; s++) begin
      grant[s] = cand[s] & ~|(cand & olderCols[s*N +: N]);
    end
    anyGrant = |grant;
  end

endmodule

// File: rtl/age_sel_datapath.sv
module age_sel_datapath
  import age_sel_pkg::*;
#(
  parameter int N = 16,
  parameter int P = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  ageStrobeT      strobe,
  input  logic [N-1:0]   allocMask,
  input  logic [N-1:0]   deallocMask,
  input  logic [N-1:0]   validVec,
  input  logic [N-1:0]   survivorVec,
  input  logic [N-1:0]   readyVec,
  input  logic [N*P-1:0] reqPort,
  output logic [N*P-1:0] grantVec,
  output logic [P-1:0]   grantValid
);

  // ageM[i][j] set: slot i was filled before slot j
  logic [N-1:0]   ageM [N];
  logic [N*N-1:0] olderCols;
  logic           pairOrderOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) ageM[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (strobe.allocHit && allocMask[j])
            ageM[i][j] <= survivorVec[i];          // every survivor is older
          else if (strobe.allocHit && allocMask[i])
            ageM[i][j] <= 1'b0;                    // newcomer older than none
          else if (strobe.deallocHit && (deallocMask[i] || deallocMask[j]))
            ageM[i][j] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < N; s++)
      for (int j = 0; j < N; j++)
        olderCols[s*N+j] = ageM[j][s];
  end

  for (genvar p = 0; p < P; p++) begin : gPort
    logic [N-1:0] reqThis;
    logic [N-1:0] cand;
    always_comb begin
      for (int s = 0; s < N; s++) reqThis[s] = reqPort[s*P+p];
      cand = validVec & readyVec & reqThis;
    end

    age_sel_picker #(.N(N)) uPick (
      .cand     (cand),
      .olderCols(olderCols),
      .grant    (grantVec[p*N +: N]),
      .anyGrant (grantValid[p])
    );

    assert_grant_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(grantVec[p*N +: N]));
    assert_grant_eligible_R2: assert property (@(posedge clk) disable iff (!rstN)
      (grantVec[p*N +: N] & ~(validVec & readyVec & reqThis)) == '0);
    assert_valid_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
      grantValid[p] == ((validVec & readyVec & reqThis) != '0));
  end

  always_comb begin
    pairOrderOk = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (ageM[i][i]) pairOrderOk = 1'b0;
      for (int j = 0; j < N; j++)
        if (i != j && validVec[i] && validVec[j] && (ageM[i][j] == ageM[j][i]))
          pairOrderOk = 1'b0;
    end
  end

  // R3: occupied slots always form a strict order
  assert_total_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    pairOrderOk);

endmodule

// File: rtl/age_oldest_select.sv
module age_oldest_select
  import age_sel_pkg::*;
#(
  parameter  int N  = 16,
  parameter  int P  = 2,
  localparam int IW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           allocEn,
  input  logic [IW-1:0]  allocIdx,
  input  logic           deallocEn,
  input  logic [IW-1:0]  deallocIdx,
  input  logic [N-1:0]   readyVec,
  input  logic [N*P-1:0] reqPort,
  output logic [N*P-1:0] grantVec,
  output logic [P-1:0]   grantValid
);

  ageStrobeT    strobe;
  logic [N-1:0] allocMask, deallocMask, validVec, survivorVec;

  age_sel_ctrl #(.N(N), .IW(IW)) uCtrl (
    .clk(clk), .rstN(rstN),
    .allocEn(allocEn), .allocIdx(allocIdx),
    .deallocEn(deallocEn), .deallocIdx(deallocIdx),
    .strobe(strobe), .allocMask(allocMask), .deallocMask(deallocMask),
    .validVec(validVec), .survivorVec(survivorVec)
  );

  age_sel_datapath #(.N(N), .P(P)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .allocMask(allocMask), .deallocMask(deallocMask),
    .validVec(validVec), .survivorVec(survivorVec),
    .readyVec(readyVec), .reqPort(reqPort),
    .grantVec(grantVec), .grantValid(grantValid)
  );

endmodule

// File: tb/sim_age_oldest_select.sv
module sim_age_oldest_select;

  localparam int N = 16;
  localparam int P = 2;
  localparam int IW = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           allocEn = 1'b0;
  logic [IW-1:0]  allocIdx = '0;
  logic           deallocEn = 1'b0;
  logic [IW-1:0]  deallocIdx = '0;
  logic [N-1:0]   readyVec = '0;
  logic [N-1:0]   p1Mask = '0;
  logic [N*P-1:0] reqPort;
  logic [N*P-1:0] grantVec;
  logic [P-1:0]   grantValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // reference model: occupancy and fill stamps
  bit mValid [N];
  int stamp  [N];
  int nextStamp = 0;

  always #2 clk = ~clk;  // 250 MHz

  // each slot requests port 1 if its p1Mask bit is set, else port 0
  always_comb begin
    for (int s = 0; s < N; s++) begin
      reqPort[s*P+1] = p1Mask[s];
      reqPort[s*P]   = ~p1Mask[s];
    end
  end

  age_oldest_select u0 (
    .clk(clk), .rstN(rstN),
    .allocEn(allocEn), .allocIdx(allocIdx),
    .deallocEn(deallocEn), .deallocIdx(deallocIdx),
    .readyVec(readyVec), .reqPort(reqPort),
    .grantVec(grantVec), .grantValid(grantValid)
  );

  // upper half: port-1 mask, lower half: ready mask
  localparam logic [31:0] PAT [10] = '{
    32'h0000_FFFF, 32'hFFFF_FFFF, 32'h0021_FFFF, 32'h4000_C281,
    32'h0001_4284, 32'h0204_4204, 32'h0000_0080, 32'h4080_4081,
    32'h0008_FFF7, 32'h0000_0000
  };

  function automatic logic [N-1:0] expPick(logic [N-1:0] rdy, logic [N-1:0] p1, int p);
    int best = -1;
    logic [N-1:0] r = '0;
    for (int s = 0; s < N; s++)
      if (mValid[s] && rdy[s] && ((p == 1) ? p1[s] : !p1[s]))
        if (best < 0 || stamp[s] < stamp[best]) best = s;
    if (best >= 0) r[best] = 1'b1;
    return r;
  endfunction

  task automatic checkPorts(string tag);
    for (int p = 0; p < P; p++) begin
      logic [N-1:0] e = expPick(readyVec, p1Mask, p);
      nChecks++;
      if (grantVec[p*N +: N] !== e || grantValid[p] !== (e != '0)) begin
        nFails++;
        $display("FAIL %s port %0d: grant=%h valid=%b expected grant=%h valid=%b",
                 tag, p, grantVec[p*N +: N], grantValid[p], e, (e != '0));
      end
    end
  endtask

  task automatic edgeStep();
    @(posedge clk); #1;
  endtask

  task automatic doAlloc(int idx);
    allocEn = 1'b1; allocIdx = IW'(idx);
    @(posedge clk);
    mValid[idx] = 1'b1; stamp[idx] = nextStamp; nextStamp++;
    #1 allocEn = 1'b0;
  endtask

  task automatic doDealloc(int idx);
    deallocEn = 1'b1; deallocIdx = IW'(idx);
    @(posedge clk);
    mValid[idx] = 1'b0;
    #1 deallocEn = 1'b0;
  endtask

  task automatic doBoth(int idx);
    allocEn = 1'b1; allocIdx = IW'(idx);
    deallocEn = 1'b1; deallocIdx = IW'(idx);
    @(posedge clk);
    mValid[idx] = 1'b1; stamp[idx] = nextStamp; nextStamp++;
    #1 allocEn = 1'b0; deallocEn = 1'b0;
  endtask

  initial begin
    for (int s = 0; s < N; s++) begin mValid[s] = 1'b0; stamp[s] = 0; end
    readyVec = '1; p1Mask = 16'h00FF;
    repeat (3) @(posedge clk);
    #1;
    checkPorts("R1 in reset");
    rstN = 1'b1;
    edgeStep();
    checkPorts("R1 after reset");

    // R11: a fresh slot competes in the next cycle
    readyVec = '1; p1Mask = '0;
    doAlloc(5);
    #1 checkPorts("R11 first alloc");
    doAlloc(2); doAlloc(9); doAlloc(0); doAlloc(14); doAlloc(7);

    // R3/R7/R2: pattern table against scrambled fill order 5,2,9,0,14,7
    for (int k = 0; k < 10; k++) begin
      readyVec = PAT[k][15:0];
      p1Mask   = PAT[k][31:16];
      #1 checkPorts($sformatf("R3 R7 R2 pattern %0d", k));
      edgeStep();
    end

    // R5/R2: free the oldest slot, stale ready and request remain
    readyVec = '1; p1Mask = 16'h0200;
    doDealloc(5);
    #1 checkPorts("R5 R2 after freeing oldest");
    readyVec = 16'h0024; p1Mask = '0;
    #1 checkPorts("R2 freed slot with stale ready");

    // R6: refill and free slot 2 at the same edge
    readyVec = '1; p1Mask = '0;
    doBoth(2);
    #1 checkPorts("R6 same-slot alloc and free");
    readyVec = 16'h0004;
    #1 checkPorts("R6 slot stays occupied");

    // R4: refill slot 5 -> youngest
    doAlloc(5);
    readyVec = 16'h00A0; p1Mask = '0;
    #1 checkPorts("R4 refilled slot is youngest");
    readyVec = 16'h0024;
    #1 checkPorts("R4 R6 order between refilled slots");

    // R8: nothing eligible
    readyVec = '0;
    #1 checkPorts("R8 no ready slot");
    readyVec = 16'h0F00 & ~16'h0200; p1Mask = '1;
    #1 checkPorts("R8 only empty slots ready");

    // R9: mid-cycle change reflected without a clock edge
    @(negedge clk);
    readyVec = 16'h4080; p1Mask = 16'h4000;
    #0.5 checkPorts("R9 combinational response a");
    readyVec = 16'h4001;
    #0.5 checkPorts("R9 combinational response b");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule